// File: doc/BRIEF.md
# Programmable CRC Generator

This unit computes a cyclic redundancy check of up to 32 bits over a byte stream. The CRC definition is set at run time. Two definition sets are stored. Each set holds an initial value, a polynomial, a final XOR mask, an output field width of 8, 16 or 32 bits, and an input bit-order flag. The polynomial, initial value and mask are left-justified in 32-bit words. Each incoming byte names the set it is computed under.

A running remainder is kept between transfers, so one message can be fed in several pieces. A start flag on the first byte of a message reloads the remainder from the chosen set's initial value. When a byte carries the last flag, the final result is formed by XORing the remainder with the mask. It is then streamed out one byte per cycle, most significant byte first, with only as many bytes as the field width. A swap flag given with that last byte reverses the bit order inside every output byte. The remainder itself stays visible on an output port at all times, before the mask is applied.

Top module: `crc_gen_unit`

## Requirements
- R1: While reset is active, `partial_q` reads zero and `out_valid` is low.
- R2: A cycle with `cfg_we` high writes the initial value, polynomial, field code, final mask and bit-order flag into the definition set addressed by `cfg_set`. The other set is left unchanged.
- R3: A byte with `in_start` high is processed starting from the initial value of the set named by `in_set`. A byte without `in_start` continues from the current `partial_q`.
- R4: Each cycle with `in_valid` high consumes one byte. Bits are shifted into the left-justified remainder one at a time. For each bit, the feedback is remainder bit 31 XOR the data bit, the remainder moves left by one, and the polynomial is XORed in when the feedback is 1. The new remainder appears on `partial_q` after the next clock edge.
- R5: With the set's bit-order flag at 1, bit 7 of each byte is fed first. With the flag at 0, bit 0 is fed first.
- R6: Field code 0 selects an 8-bit CRC, 1 selects 16 bits, and 2 or 3 select 32 bits. Narrow CRCs live in the upper bits of every 32-bit word, and their unused lower bits must be zero.
- R7: `partial_q` holds the remainder without the final mask and does not change in cycles without `in_valid`.
- R8: After a byte with `in_last`, the result (remainder XOR mask) is emitted starting the next cycle. It comes out as 1, 2 or 4 consecutive bytes for widths 8, 16 and 32, from bits 31:24 downward. `out_last` marks the final byte, and `out_valid` then drops.
- R9: When `in_swap` is high with the last byte, every output byte is bit-reversed, so the first byte carries result bits 24 up to 31.
- R10: The two definition sets are independent, and consecutive bytes may use different sets.
- R11: With polynomial 0x04C11DB7, initial value and mask 0xFFFFFFFF, 32-bit width and bit 7 first, the ASCII string "123456789" yields 0xFC891918.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Definition write strobe |
| cfg_set | input | SEL_W | Definition set to write |
| cfg_init | input | 32 | Initial value, left-justified |
| cfg_poly | input | 32 | Polynomial, left-justified |
| cfg_fld | input | 2 | Field width code (0:8, 1:16, 2/3:32) |
| cfg_fxor | input | 32 | Final XOR mask, left-justified |
| cfg_msb_first | input | 1 | 1: bit 7 fed first; 0: bit 0 fed first |
| in_valid | input | 1 | Data byte present |
| in_byte | input | 8 | Data byte |
| in_start | input | 1 | Restart from the initial value |
| in_last | input | 1 | Final byte; emit the result |
| in_set | input | SEL_W | Definition set used for this byte |
| in_swap | input | 1 | Bit-reverse each output byte |
| partial_q | output | 32 | Running remainder, without the mask |
| out_valid | output | 1 | Result byte present |
| out_byte | output | 8 | Result byte |
| out_last | output | 1 | Final result byte |

## Verification
The bench uses the default build: two definition sets and a two-stage reset synchronizer. This makes it possible to sweep every byte value through both sets, under every width code in use and both bit orders, with the output swap toggled along the way. Multi-byte messages then exercise restart, continuation across idle cycles and a mid-stream set change. The 32-bit check string pins the arithmetic to a known published value.

// File: rtl/crc_gen_pkg.sv
package crc_gen_pkg;
  localparam int CRC_W  = 32;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    FLD_8   = 2'd0,
    FLD_16  = 2'd1,
    FLD_32  = 2'd2,
    FLD_32B = 2'd3
  } fld_e;

  typedef struct packed {
    logic [CRC_W-1:0] init;
    logic [CRC_W-1:0] poly;
    fld_e             fld;
    logic [CRC_W-1:0] fxor;
    logic             msb_first;
  } crc_def_t;

  function automatic logic [BYTE_W-1:0] rev_byte(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
    return r;
  endfunction

  function automatic logic [2:0] fld_bytes(input fld_e f);
    case (f)
      FLD_8:   return 3'd1;
      FLD_16:  return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/crc_rst_sync.sv
module crc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/crc_def_bank.sv
module crc_def_bank
  import crc_gen_pkg::*;
#(
  parameter int NUM_SETS = 2,
  localparam int SEL_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] wsel,
  input  crc_def_t         wdef,
  output crc_def_t         defs [NUM_SETS]
);
  for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
    crc_def_t def_q;
    logic     wen;

    assign wen = we && (wsel == SEL_W'(g));

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n)  def_q <= '0;
      else if (wen) def_q <= wdef;
    end

    assign defs[g] = def_q;
  end
endmodule

// File: rtl/crc_byte_engine.sv
module crc_byte_engine
  import crc_gen_pkg::*;
(
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [CRC_W-1:0]  poly,
  input  logic [BYTE_W-1:0] data,
  input  logic              msb_first,
  output logic [CRC_W-1:0]  crc_out
);
  logic [BYTE_W-1:0] ordered;
  logic [CRC_W-1:0]  acc;
  logic              fb;

  always_comb begin
    ordered = msb_first ? data : rev_byte(data);
    acc     = crc_in;
    fb      = 1'b0;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      fb  = acc[CRC_W-1] ^ ordered[i];
      acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end
    crc_out = acc;
  end
endmodule

// File: rtl/crc_out_serializer.sv
module crc_out_serializer
  import crc_gen_pkg::*;
(
  input  logic              clk,
  input  logic              srst_n,
  input  logic              load,
  input  logic [CRC_W-1:0]  result,
  input  logic [2:0]        nbytes,
  input  logic              swap,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_last
);
  logic [CRC_W-1:0] sh_q, sh_d;
  logic [2:0]       cnt_q, cnt_d;
  logic             swap_q, swap_d;
  logic             en;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    swap_d = swap_q;
    if (load) begin
      sh_d   = result;
      cnt_d  = nbytes;
      swap_d = swap;
    end else if (cnt_q != 3'd0) begin
      sh_d  = {sh_q[CRC_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
      cnt_d = cnt_q - 3'd1;
    end
  end

  assign en = load || (cnt_q != 3'd0);

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      swap_q <= 1'b0;
    end else if (en) begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      swap_q <= swap_d;
    end
  end

  assign out_valid = (cnt_q != 3'd0);
  assign out_last  = (cnt_q == 3'd1);
  assign out_byte  = swap_q ? rev_byte(sh_q[CRC_W-1 -: BYTE_W]) : sh_q[CRC_W-1 -: BYTE_W];
endmodule

// File: rtl/crc_gen_unit.sv
module crc_gen_unit
  import crc_gen_pkg::*;
#(
  parameter int NUM_SETS    = 2,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_set,
  input  logic [31:0]      cfg_init,
  input  logic [31:0]      cfg_poly,
  input  logic [1:0]       cfg_fld,
  input  logic [31:0]      cfg_fxor,
  input  logic             cfg_msb_first,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             in_start,
  input  logic             in_last,
  input  logic [SEL_W-1:0] in_set,
  input  logic             in_swap,
  output logic [31:0]      partial_q,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic             out_last
);
  logic       srst_n;
  crc_def_t   wr_def;
  crc_def_t   defs [NUM_SETS];
  crc_def_t   cur_def;
  logic [CRC_W-1:0] base;
  logic [CRC_W-1:0] crc_nxt;
  logic             emit;

  crc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  assign wr_def = '{init:      cfg_init,
                    poly:      cfg_poly,
                    fld:       fld_e'(cfg_fld),
                    fxor:      cfg_fxor,
                    msb_first: cfg_msb_first};

  crc_def_bank #(.NUM_SETS(NUM_SETS)) u_bank (
    .clk    (clk),
    .srst_n (srst_n),
    .we     (cfg_we),
    .wsel   (cfg_set),
    .wdef   (wr_def),
    .defs   (defs)
  );

  assign cur_def = defs[in_set];
  assign base    = in_start ? cur_def.init : partial_q;

  crc_byte_engine u_eng (
    .crc_in    (base),
    .poly      (cur_def.poly),
    .data      (in_byte),
    .msb_first (cur_def.msb_first),
    .crc_out   (crc_nxt)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)       partial_q <= '0;
    else if (in_valid) partial_q <= crc_nxt;
  end

  assign emit = in_valid && in_last;

  crc_out_serializer u_ser (
    .clk       (clk),
    .srst_n    (srst_n),
    .load      (emit),
    .result    (crc_nxt ^ cur_def.fxor),
    .nbytes    (fld_bytes(cur_def.fld)),
    .swap      (in_swap),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .out_last  (out_last)
  );
endmodule

// File: rtl/crc_gen_unit_chk.sv
module crc_gen_unit_chk (
  input logic        clk,
  input logic        srst_n,
  input logic        in_valid,
  input logic        in_last,
  input logic [31:0] partial_q,
  input logic        out_valid,
  input logic        out_last
);
  // R8
  last_starts_burst_chk: assert property (@(posedge clk) disable iff (!srst_n)
    in_valid && in_last |=> out_valid);

  // R8
  burst_gapless_chk: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid && !out_last |=> out_valid);

  // R8
  burst_ends_chk: assert property (@(posedge clk) disable iff (!srst_n)
    out_valid && out_last && !(in_valid && in_last) |=> !out_valid);

  // R7
  idle_partial_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !in_valid |=> $stable(partial_q));
endmodule

bind crc_gen_unit crc_gen_unit_chk u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .in_valid  (in_valid),
  .in_last   (in_last),
  .partial_q (partial_q),
  .out_valid (out_valid),
  .out_last  (out_last)
);

// File: tb/crc_gen_unit_tb.sv
`timescale 1ns/1ps
module crc_gen_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_msb_first;
  logic [0:0]  cfg_set, in_set;
  logic [31:0] cfg_init, cfg_poly, cfg_fxor;
  logic [1:0]  cfg_fld;
  logic        in_valid, in_start, in_last, in_swap;
  logic [7:0]  in_byte;
  logic [31:0] partial_q;
  logic        out_valid, out_last;
  logic [7:0]  out_byte;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_init [2];
  logic [31:0] m_poly [2];
  logic [31:0] m_xor  [2];
  logic [1:0]  m_fld  [2];
  logic        m_msbf [2];
  logic [31:0] m_part;
  logic [31:0] last_got;

  always #10 clk = ~clk;

  crc_gen_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_set(cfg_set), .cfg_init(cfg_init), .cfg_poly(cfg_poly),
    .cfg_fld(cfg_fld), .cfg_fxor(cfg_fxor), .cfg_msb_first(cfg_msb_first),
    .in_valid(in_valid), .in_byte(in_byte), .in_start(in_start), .in_last(in_last),
    .in_set(in_set), .in_swap(in_swap),
    .partial_q(partial_q), .out_valid(out_valid), .out_byte(out_byte), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rv8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  // serial division over the wire-order bit sequence
  function automatic logic [31:0] ref_byte(input logic [31:0] c, input logic [31:0] p,
                                           input logic [7:0] b, input logic msbf);
    logic [31:0] r;
    logic bitv;
    r = c;
    for (int k = 0; k < 8; k++) begin
      bitv = msbf ? b[7-k] : b[k];
      if (r[31] ^ bitv) r = (r << 1) ^ p;
      else              r = r << 1;
    end
    return r;
  endfunction

  task automatic program_set(input int s, input logic [31:0] ini, input logic [31:0] pol,
                             input logic [1:0] fld, input logic [31:0] fx, input logic msbf);
    @(negedge clk);
    cfg_we = 1'b1; cfg_set = s[0]; cfg_init = ini; cfg_poly = pol;
    cfg_fld = fld; cfg_fxor = fx; cfg_msb_first = msbf;
    @(negedge clk);
    cfg_we = 1'b0;
    m_init[s] = ini; m_poly[s] = pol; m_fld[s] = fld; m_xor[s] = fx; m_msbf[s] = msbf;
  endtask

  task automatic xfer(input int s, input logic [7:0] b, input bit st, input bit lst,
                      input bit sw, input string tag);
    logic [31:0] base, res, got, exp;
    int nb;
    bit ok;
    @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_start = st; in_last = lst; in_set = s[0]; in_swap = sw;
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0; in_swap = 1'b0;
    base = st ? m_init[s] : m_part;
    m_part = ref_byte(base, m_poly[s], b, m_msbf[s]);
    check(partial_q == m_part, tag, partial_q, m_part);
    if (lst) begin
      res = m_part ^ m_xor[s];
      nb = (m_fld[s] == 2'd0) ? 1 : (m_fld[s] == 2'd1) ? 2 : 4;
      ok = 1'b1; got = '0; exp = '0;
      for (int k = 0; k < nb; k++) begin
        logic [7:0] eb;
        eb = res[31-8*k -: 8];
        if (sw) eb = rv8(eb);
        exp = {exp[23:0], eb};
        got = {got[23:0], out_byte};
        if (!out_valid || (out_last != (k == nb - 1))) ok = 1'b0;
        @(negedge clk);
      end
      if (out_valid) ok = 1'b0;
      last_got = got;
      check(ok && (got == exp), {tag, " R8 output"}, got, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] msg [9];
    rst_n = 1'b0;
    cfg_we = 0; cfg_set = 0; cfg_init = 0; cfg_poly = 0; cfg_fld = 0; cfg_fxor = 0; cfg_msb_first = 0;
    in_valid = 0; in_byte = 0; in_start = 0; in_last = 0; in_set = 0; in_swap = 0;
    m_part = '0; last_got = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(partial_q == 32'd0, "R1 partial", partial_q, 32'd0);
    check(out_valid == 1'b0, "R1 out_valid", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R4 R5 R6 R9 R10: every byte, both sets, each width, both orders
    for (int f = 0; f < 3; f++) begin
      for (int o = 0; o < 2; o++) begin
        case (f)
          0: begin
            program_set(0, 32'hA500_0000, 32'h0700_0000, 2'd0, 32'h5A00_0000, o[0]);
            program_set(1, 32'h0000_0000, 32'h3100_0000, 2'd0, 32'h0000_0000, !o[0]);
          end
          1: begin
            program_set(0, 32'hFFFF_0000, 32'h8005_0000, 2'd1, 32'h00FF_0000, o[0]);
            program_set(1, 32'h1D0F_0000, 32'h1021_0000, 2'd1, 32'hFFFF_0000, !o[0]);
          end
          default: begin
            program_set(0, 32'hFFFF_FFFF, 32'h04C1_1DB7, (o == 0) ? 2'd2 : 2'd3, 32'hFFFF_FFFF, o[0]);
            program_set(1, 32'h0000_0000, 32'h1EDC_6F41, 2'd2, 32'h0F0F_0F0F, !o[0]);
          end
        endcase
        for (int b = 0; b < 256; b++)
          xfer(b & 1, b[7:0], 1'b1, 1'b1, b[2], "R2 R4 R5 R6 R9 R10 sweep");
      end
    end

    // R11 check string, 32-bit, bit 7 first
    program_set(0, 32'hFFFF_FFFF, 32'h04C1_1DB7, 2'd2, 32'hFFFF_FFFF, 1'b1);
    for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
    for (int i = 0; i < 9; i++) xfer(0, msg[i], i == 0, i == 8, 1'b0, "R11 message");
    check(last_got == 32'hFC89_1918, "R11 check value", last_got, 32'hFC89_1918);

    // R3 R7: pieces with idle gaps, then a restart in mid-message
    program_set(1, 32'h1D0F_0000, 32'h1021_0000, 2'd1, 32'h0000_0000, 1'b0);
    for (int i = 0; i < 9; i++) begin
      xfer(1, msg[i], i == 0, 1'b0, 1'b0, "R3 continue");
      repeat (3) @(negedge clk);
      check(partial_q == m_part, "R7 idle hold", partial_q, m_part);
    end
    xfer(1, 8'hC3, 1'b1, 1'b0, 1'b0, "R3 restart");
    xfer(1, 8'h3C, 1'b0, 1'b1, 1'b1, "R3 R9 restart tail");

    // R10: alternating sets inside one remainder chain
    for (int i = 0; i < 8; i++) xfer(i & 1, msg[i], i == 0, i == 7, i[0], "R10 alternating");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule